// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data words between two ports, A and B, over two independent paths: A-to-B and B-to-A. Each path owns one storage element. A latch-enable input selects its mode. With the latch enable high the storage is transparent. With it low, the storage becomes a register loaded on a falling edge of that path's data clock. An output enable per path decides whether the receiving port drives. The A-to-B enable is active high and the B-to-A enable is active low. Drive is modelled as a data word plus a drive-enable flag, not as a real three-state pin.

The block runs in one system clock domain, and every control pin is sampled there like any other synchronous input. A data clock edge is found by comparing the current sample with the one registered a cycle earlier. Each incoming port has a keeper register. While the port is marked as not driven, the keeper supplies the last value seen while it was driven, so a floating input never reaches storage as an unknown value. Results appear on the outputs one system clock after the inputs that cause them.

Top module: `bidir_xcvr`

## Requirements
- R1: After reset both storage elements hold zero, both drive flags are low and both keepers hold zero; the word width is a parameter, 18 by default.
- R2: While the A-to-B latch enable is 1, the B data output equals, one system clock later, the effective A input of the cycle before.
- R3: While the A-to-B latch enable is 0 and the A-to-B data clock sample equals its previous sample, the B data output does not change.
- R4: While the A-to-B latch enable is 0, a cycle where the previous data clock sample is 1 and the current one is 0 loads the effective A input, visible on the B data output one clock later.
- R5: While the A-to-B latch enable is 0, a rising data clock (previous 0, current 1) leaves the B data output unchanged.
- R6: The B drive flag equals, one clock later, the A-to-B output enable (1 means drive).
- R7: The B-to-A path follows the rules of R2 to R5, using its own latch enable and data clock, storing the effective B input and presenting it on the A data output.
- R8: The A drive flag equals, one clock later, the inverse of the B-to-A output enable (0 means drive).
- R9: When a port's valid input is 0, its effective input is the last word presented while valid was 1, or zero if it has not been valid since reset; when valid is 1 the effective input is the port's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | Word arriving on port A |
| a_in_vld | input | 1 | Port A is externally driven |
| b_in | input | W | Word arriving on port B |
| b_in_vld | input | 1 | Port B is externally driven |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_dclk | input | 1 | A-to-B data clock, sampled |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_dclk | input | 1 | B-to-A data clock, sampled |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | W | Word presented on port B |
| b_drv | output | 1 | Port B drives b_out |
| a_out | output | W | Word presented on port A |
| a_drv | output | 1 | Port A drives a_out |

## Verification
The bench builds the block with its default width of 18, so each data word is a full random 18-bit vector. Both paths are driven at once with independent random control bits over a long run. Every pairing of latch enable, previous and current data clock sample, output enable and input valid then comes up many times in each direction, including loads made from kept values. A model written from the requirements predicts the stored word and the drive flag for every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Falling data clock seen between two system clock samples.
  function automatic logic is_fall(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction

  // Storage takes a new word when transparent or on a falling data clock.
  function automatic logic takes_word(input logic le, input logic fall);
    return le | fall;
  endfunction

  // Map an output-enable pin to a drive request given its polarity.
  function automatic logic drive_req(input logic oe_pin, input logic act_low);
    return act_low ? ~oe_pin : oe_pin;
  endfunction

endpackage

// File: rtl/port_keeper.sv
module port_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic         pin_vld,
  output logic [W-1:0] eff
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (pin_vld) held <= pin;
  end

  assign eff = pin_vld ? pin : held;

  p_keep_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_vld |=> $stable(held));
  p_keep_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_vld |=> held == $past(pin));
endmodule

// File: rtl/xfer_path.sv
module xfer_path #(
  parameter int W      = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         dclk,
  input  logic         oe,
  output logic [W-1:0] q,
  output logic         drv
);
  import xcvr_pkg::*;

  logic dclk_prev;
  logic fall_evt;
  logic load_evt;
  logic oe_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_prev <= 1'b0;
    else        dclk_prev <= dclk;
  end

  assign fall_evt = is_fall(dclk_prev, dclk);
  assign load_evt = takes_word(le, fall_evt);

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe_on = drive_req(oe, 1'b1);
    end else begin : g_oe_high
      assign oe_on = drive_req(oe, 1'b0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      drv <= 1'b0;
    end else begin
      if (load_evt) q <= din;
      drv <= oe_on;
    end
  end

  // R2 on the A-to-B instance, R7 on the B-to-A instance.
  p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> q == $past(din));
  // R4 / R7
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && dclk_prev && !dclk) |=> q == $past(din));
  // R5 / R7
  p_rise_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !dclk_prev && dclk) |=> $stable(q));
  // R3 / R7
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && (dclk_prev == dclk)) |=> $stable(q));

  generate
    if (OE_LOW) begin : g_chk_low
      p_oe_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe |=> !drv);
    end else begin : g_chk_high
      p_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe |=> drv);
    end
  endgenerate
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_in_vld,
  input  logic [W-1:0] b_in,
  input  logic         b_in_vld,
  input  logic         ab_le,
  input  logic         ab_dclk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_dclk,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv
);
  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;

  port_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .pin(a_in), .pin_vld(a_in_vld), .eff(a_eff)
  );
  port_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .pin(b_in), .pin_vld(b_in_vld), .eff(b_eff)
  );

  xfer_path #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk(clk), .rst_n(rst_n), .din(a_eff), .le(ab_le), .dclk(ab_dclk),
    .oe(ab_oe), .q(b_out), .drv(b_drv)
  );
  xfer_path #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk(clk), .rst_n(rst_n), .din(b_eff), .le(ba_le), .dclk(ba_dclk),
    .oe(ba_oe_n), .q(a_out), .drv(a_drv)
  );

  // R1: drive flags stay low while reset is applied.
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!a_drv && !b_drv);
    end
  end
endmodule

// File: tb/bidir_xcvr_tb.sv
module bidir_xcvr_tb;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         a_in_vld = 1'b0, b_in_vld = 1'b0;
  logic         ab_le = 1'b0, ab_dclk = 1'b0, ab_oe = 1'b0;
  logic         ba_le = 1'b0, ba_dclk = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic         b_drv, a_drv;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  bidir_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_in_vld(a_in_vld),
    .b_in(b_in), .b_in_vld(b_in_vld), .ab_le(ab_le), .ab_dclk(ab_dclk),
    .ab_oe(ab_oe), .ba_le(ba_le), .ba_dclk(ba_dclk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  // Model state built from the requirements.
  logic [W-1:0] m_keep_a, m_keep_b, m_q_ab, m_q_ba;
  logic         m_prev_ab, m_prev_ba, m_drv_b, m_drv_a;
  string        tag_ab, tag_ba;

  task automatic check_word(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Classify the cycle and return the next stored word for one path.
  function automatic logic [W-1:0] path_next(input logic le, input logic prv,
      input logic cur, input logic [W-1:0] word, input logic [W-1:0] q,
      input bit is_ba, input logic vld, output string tag);
    string base;
    if (le) begin
      base = is_ba ? "R7-transparent" : "R2";
      tag = vld ? base : {base, "/R9"};
      return word;
    end
    if (prv && !cur) begin
      base = is_ba ? "R7-capture" : "R4";
      tag = vld ? base : {base, "/R9"};
      return word;
    end
    if (!prv && cur) tag = is_ba ? "R7-rise" : "R5";
    else             tag = is_ba ? "R7-hold" : "R3";
    return q;
  endfunction

  task automatic step(logic le1, logic ck1, logic oe1, logic v1, logic [W-1:0] d1,
                      logic le2, logic ck2, logic oe2, logic v2, logic [W-1:0] d2);
    logic [W-1:0] ea, eb;
    a_in = d1; a_in_vld = v1; ab_le = le1; ab_dclk = ck1; ab_oe = oe1;
    b_in = d2; b_in_vld = v2; ba_le = le2; ba_dclk = ck2; ba_oe_n = oe2;
    ea = v1 ? d1 : m_keep_a;
    eb = v2 ? d2 : m_keep_b;
    m_keep_a = ea;
    m_keep_b = eb;
    m_q_ab = path_next(le1, m_prev_ab, ck1, ea, m_q_ab, 1'b0, v1, tag_ab);
    m_q_ba = path_next(le2, m_prev_ba, ck2, eb, m_q_ba, 1'b1, v2, tag_ba);
    m_prev_ab = ck1;
    m_prev_ba = ck2;
    m_drv_b = oe1;
    m_drv_a = ~oe2;
    @(negedge clk);
    check_word(tag_ab, b_out, m_q_ab);
    check_word(tag_ba, a_out, m_q_ba);
    check_bit("R6", b_drv, m_drv_b);
    check_bit("R8", a_drv, m_drv_a);
  endtask

  initial begin
    m_keep_a = '0; m_keep_b = '0; m_q_ab = '0; m_q_ba = '0;
    m_prev_ab = 1'b0; m_prev_ba = 1'b0; m_drv_a = 1'b0; m_drv_b = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is applied and after release.
    check_word("R1", b_out, '0);
    check_word("R1", a_out, '0);
    check_bit("R1", b_drv, 1'b0);
    check_bit("R1", a_drv, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1", a_drv, 1'b0);

    // Directed: R9 zero keeper after reset, loaded while not driven.
    step(1, 0, 1, 0, 18'h3ABCD, 1, 0, 0, 0, 18'h12345);
    // Directed A-to-B: transparent, then rise, hold, fall.
    step(1, 0, 1, 1, 18'h2AAAA, 1, 0, 0, 1, 18'h15555);
    step(0, 1, 1, 1, 18'h01111, 0, 1, 0, 1, 18'h02222); // R5 / R7 rise
    step(0, 1, 0, 1, 18'h03333, 0, 1, 1, 1, 18'h04444); // R3 / R7 hold
    step(0, 0, 1, 1, 18'h05555, 0, 0, 0, 1, 18'h06666); // R4 / R7 capture
    step(0, 0, 1, 0, 18'h07777, 0, 0, 0, 0, 18'h08888); // R3 with floating input
    step(0, 1, 1, 0, 18'h09999, 0, 1, 0, 0, 18'h0AAAA);
    step(0, 0, 1, 0, 18'h0BBBB, 0, 0, 0, 0, 18'h0CCCC); // R4 + R9 kept word

    // Near-exhaustive random sweep over every control pairing.
    for (int k = 0; k < 3000; k++) begin
      logic [9:0] c;
      c = 10'($urandom);
      step(c[0], c[1], c[2], c[3] | c[8], 18'($urandom) & MASK,
           c[4], c[5], c[6], c[7] | c[9], 18'($urandom) & MASK);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule